// File: doc/BRIEF.md
# Programmable-Period Three-Phase Step Timer

This block times the control steps of a sequencer from a fast base clock. Each step lasts either a short or a long number of base cycles. The sequencer picks the length one step at a time, so a quick logical step does not have to wait as long as the slowest arithmetic path. All lengths are counted in whole base cycles. With a 5 ns base clock the defaults give 45 ns and 195 ns steps.

Each step is split into three ordered phase pulses. The first pulse comes early in the step and serves fast operations. The third pulse falls on the last cycle of the step and serves slow operations. A step-end strobe on that same last cycle tells the sequencer to advance. On that cycle the sequencer also presents the length it wants for the following step. An enable input freezes the timer in place.

Top module: `step_phase_timer`

## Requirements
- R1: After reset the timer is at cycle 0 of a short step (`RESET_LONG` = 0). The first enabled cycle after reset is cycle 0, so with the defaults phase 1 pulses on the third enabled cycle.
- R2: With `selLong` = 0 selected, a step lasts `SHORT_CYCLES` enabled cycles (default 9). Its phase pulses fall on cycles 2, 5 and 8.
- R3: With `selLong` = 1 selected, a step lasts `LONG_CYCLES` enabled cycles (default 39). Its phase pulses fall on cycles 12, 25 and 38.
- R4: Phase k (k = 1..3, driven on `phasePulse[k-1]`) is high for exactly one base cycle. That cycle is number floor(k·P/3) − 1 of the step, where P is the step length and cycles are numbered from 0.
- R5: No two bits of `phasePulse` are ever high in the same cycle.
- R6: `stepEnd` is high exactly on the last cycle of each enabled step, and always together with phase 3.
- R7: `selLong` is sampled only on a cycle where `stepEnd` is high, and it sets the length of the next step. Its value on any other cycle has no effect.
- R8: While `enable` is low, `phasePulse` and `stepEnd` are low and the cycle position holds. When `enable` rises again, the step resumes from the position where it stopped.
- R9: A short step followed by a long step takes `SHORT_CYCLES` + `LONG_CYCLES` enabled cycles in total (48 with the defaults).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Lets the step counter run; when low, everything is frozen and silent |
| selLong | input | 1 | Length for the next step (1 = long, 0 = short), taken when `stepEnd` is high |
| phasePulse | output | 3 | One-cycle phase pulses; bit 0 is phase 1 |
| stepEnd | output | 1 | Marks the last cycle of the current step |

## Verification
The hardest case to reach is a step-length change racing with an enable gap. The timer has to stop in the middle of a long step, hold there, and then resume. Meanwhile `selLong` keeps toggling and may only take effect on the step-end cycle. The vector table sets up exactly this: it drops `enable` partway through a step and flips `selLong` before, during and after the gap. Every cycle is compared against a step model in the bench that counts cycles from the requirements. Directed runs then measure the first phase after reset and the combined length of a short-then-long pair.

// File: rtl/step_timer_pkg.sv
package step_timer_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic emit;     // outputs may be driven this cycle
    logic advance;  // step counter increments
    logic wrap;     // step ends: counter clears, next length loads
  } stepStrobe_t;

  // Cycle index of phase k (1-based) in a step of 'period' cycles
  function automatic int phaseCycle(input int period, input int k, input int numPhases);
    return (k * period) / numPhases - 1;
  endfunction

endpackage

// File: rtl/step_timer_ctrl.sv
module step_timer_ctrl
  import step_timer_pkg::*;
(
  input  logic        enable,
  input  logic        lastHit,
  output stepStrobe_t strobe
);

  always_comb begin
    strobe.emit    = enable;
    strobe.advance = enable && !lastHit;
    strobe.wrap    = enable && lastHit;
  end

endmodule

// File: rtl/step_timer_path.sv
module step_timer_path
  import step_timer_pkg::*;
#(
  parameter int SHORT_CYCLES = 9,
  parameter int LONG_CYCLES  = 39,
  parameter int NUM_PHASES   = 3,
  parameter bit RESET_LONG   = 1'b0,
  localparam int CNT_W       = $clog2(LONG_CYCLES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  selLong,
  input  stepStrobe_t           strobe,
  output logic [NUM_PHASES-1:0] phaseHit,
  output logic                  lastHit,
  output logic [CNT_W-1:0]      stepCnt
);

  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYCLES - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYCLES - 1);

  logic curLong;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stepCnt <= '0;
      curLong <= RESET_LONG;
    end else if (strobe.wrap) begin
      stepCnt <= '0;
      curLong <= selLong;
    end else if (strobe.advance) begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

  assign lastHit = curLong ? (stepCnt == LONG_LAST) : (stepCnt == SHORT_LAST);

  for (genvar k = 0; k < NUM_PHASES; k++) begin : g_phase
    localparam logic [CNT_W-1:0] POS_SHORT =
      CNT_W'(phaseCycle(SHORT_CYCLES, k + 1, NUM_PHASES));
    localparam logic [CNT_W-1:0] POS_LONG =
      CNT_W'(phaseCycle(LONG_CYCLES, k + 1, NUM_PHASES));
    assign phaseHit[k] = curLong ? (stepCnt == POS_LONG) : (stepCnt == POS_SHORT);
  end

endmodule

// File: rtl/step_phase_timer.sv
module step_phase_timer
  import step_timer_pkg::*;
#(
  parameter int SHORT_CYCLES = 9,
  parameter int LONG_CYCLES  = 39,
  parameter int NUM_PHASES   = 3,
  parameter bit RESET_LONG   = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  selLong,
  output logic [NUM_PHASES-1:0] phasePulse,
  output logic                  stepEnd
);

  localparam int CNT_W = $clog2(LONG_CYCLES);

  stepStrobe_t           strobe;
  logic [NUM_PHASES-1:0] phaseHit;
  logic                  lastHit;
  logic [CNT_W-1:0]      stepCnt;

  step_timer_ctrl ctrl_i (
    .enable  (enable),
    .lastHit (lastHit),
    .strobe  (strobe)
  );

  step_timer_path #(
    .SHORT_CYCLES (SHORT_CYCLES),
    .LONG_CYCLES  (LONG_CYCLES),
    .NUM_PHASES   (NUM_PHASES),
    .RESET_LONG   (RESET_LONG)
  ) path_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .selLong  (selLong),
    .strobe   (strobe),
    .phaseHit (phaseHit),
    .lastHit  (lastHit),
    .stepCnt  (stepCnt)
  );

  assign phasePulse = phaseHit & {NUM_PHASES{strobe.emit}};
  assign stepEnd    = strobe.wrap;

endmodule

// File: rtl/step_timer_chk.sv
module step_timer_chk #(
  parameter int NUM_PHASES = 3,
  parameter int CNT_W      = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  enable,
  input logic [NUM_PHASES-1:0] phasePulse,
  input logic                  stepEnd,
  input logic [CNT_W-1:0]      stepCnt
);

  // R5
  phase_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phasePulse));

  // R6
  end_with_last_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stepEnd |-> phasePulse[NUM_PHASES-1]);

  // R8
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (phasePulse == '0) && !stepEnd);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> stepCnt == $past(stepCnt));

  // R4
  phase_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phasePulse[0] |=> !phasePulse[0]);

  // R6
  restart_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stepEnd |=> stepCnt == '0);

endmodule

bind step_phase_timer step_timer_chk #(
  .NUM_PHASES (NUM_PHASES),
  .CNT_W      (CNT_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .phasePulse (phasePulse),
  .stepEnd    (stepEnd),
  .stepCnt    (stepCnt)
);

// File: tb/step_phase_timer_tb.sv
`timescale 1ns/1ps
module step_phase_timer_tb_top;

  localparam int CLK_PERIOD = 5;
  localparam int SHORT_P    = 9;
  localparam int LONG_P     = 39;
  localparam int NV         = 9;

  // {enable, selLong, cycle count}
  localparam logic [9:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'd20},
    {1'b1, 1'b1, 8'd7},
    {1'b0, 1'b0, 8'd5},
    {1'b1, 1'b0, 8'd30},
    {1'b0, 1'b1, 8'd4},
    {1'b1, 1'b1, 8'd60},
    {1'b1, 1'b0, 8'd45},
    {1'b0, 1'b0, 8'd3},
    {1'b1, 1'b1, 8'd25}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       selLong = 1'b0;
  logic [2:0] phasePulse;
  logic       stepEnd;

  int checks = 0;
  int fails  = 0;
  int mCnt   = 0;
  logic mLong = 1'b0;
  bit done = 1'b0;

  step_phase_timer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .selLong    (selLong),
    .phasePulse (phasePulse),
    .stepEnd    (stepEnd)
  );

  always #(CLK_PERIOD/2.0) clk = ~clk;

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive, compare against model, advance model
  task automatic runCycle(input logic e, input logic s);
    int per;
    logic [2:0] expPh;
    logic expEnd;
    string tag;
    @(negedge clk);
    enable = e;
    selLong = s;
    #1;
    per = mLong ? LONG_P : SHORT_P;
    expPh = '0;
    for (int k = 1; k <= 3; k++)
      if (e && mCnt == (k * per) / 3 - 1) expPh[k-1] = 1'b1;
    expEnd = e && (mCnt == per - 1);
    if (!e) tag = "R8";
    else if (expEnd) tag = "R6";
    else if (expPh != 0) tag = "R4";
    else if (mLong) tag = "R3";
    else tag = "R2";
    check(tag, {stepEnd, phasePulse}, {expEnd, expPh});
    check("R5", {3'b0, $countones(phasePulse) > 1}, 4'b0);
    if (e) begin
      if (mCnt == per - 1) begin
        mCnt = 0;
        mLong = s;  // R7: taken only on step end
      end else begin
        mCnt++;
      end
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    enable = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mCnt = 0;
    mLong = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    int firstEnd;
    doReset();
    // R1: reset outputs quiet
    #1;
    check("R1", {stepEnd, phasePulse}, 4'b0);

    // Table walk (R2, R3, R4, R5, R6, R7, R8)
    for (int v = 0; v < NV; v++)
      for (int c = 0; c < int'(VEC[v][7:0]); c++)
        runCycle(VEC[v][9], VEC[v][8]);

    // R1: first phase pulse on third enabled cycle after reset
    doReset();
    n = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      enable = 1'b1;
      selLong = 1'b0;
      #1;
      if (phasePulse[0]) begin
        n = c;
        break;
      end
    end
    check("R1", 4'(n), 4'd2);

    // R9: short step then long step spans 48 enabled cycles
    doReset();
    firstEnd = -1;
    n = 0;
    for (int c = 0; c < 120; c++) begin
      @(negedge clk);
      enable = 1'b1;
      selLong = 1'b1;
      #1;
      if (stepEnd) begin
        if (firstEnd < 0) firstEnd = c;
        else begin
          n = c + 1;
          break;
        end
      end
    end
    check("R9", 4'(firstEnd + 1 == SHORT_P), 4'd1);
    check("R9", 4'(n == SHORT_P + LONG_P), 4'd1);

    // R7: selLong toggling mid-step is ignored
    doReset();
    for (int c = 0; c < 8; c++) runCycle(1'b1, 1'b1);
    runCycle(1'b1, 1'b0);  // step end takes short
    for (int c = 0; c < 9; c++) runCycle(1'b1, c[0]);
    check("R7", 4'(mCnt), 4'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule